// File: doc/BRIEF.md
# Dual-Channel Split-Phase Pulse Generator

This block drives two independent pulse outputs. Each output is described by a pair of 16-bit counts. The output stays high for the first count of prescaled steps. It then stays low for the second count, and the pattern repeats. A 32-bit word-addressed register file holds one phase-count word per channel. It also holds one control word that both channels share. The control word sets, for each channel, a 7-bit prescaler, a prescaler enable, a 2-bit time-base select, a run enable and an alternate-mode flag.

The four time bases are single-cycle enable strobes on `src_tick`, all in the one `clk` domain. Code 0 is nominally the crystal strobe and codes 1 to 3 are alternate sources. A channel's prescaler counts strobes of its selected source and issues one step every (div+1) strobes. A new phase-count word waits in the register file and is taken up only at the end of the running period. Register words 3 to 7 have no function and only store what is written to them.

Top module: `pwm2_top`

## Requirements
- R1: `bus_addr` is a word index (byte address divided by 4). Word 0 holds channel A's phase counts, word 1 holds channel B's, word 2 is the shared control word, and words 3 to 7 only store data. A write with `bus_wr` high lands on the next clock edge. `bus_rdata` returns all 32 stored bits of the addressed word combinationally.
- R2: In a phase-count word, bits 31:16 are the high count and bits 15:0 are the low count. A running channel is high for hi×(div+1) ticks of its selected source, then low for lo×(div+1) ticks, and repeats.
- R3: The prescaler field is control bits 14:8 for A and 22:16 for B. It divides the selected tick stream by its value plus one, from 1 up to 128.
- R4: The source select is control bits 5:4 for A and 7:6 for B. Code n chooses `src_tick[n]`.
- R5: A channel runs only when three conditions hold: its run enable is set (bit 0 for A, bit 1 for B), its prescaler enable is set (bit 15 for A, bit 23 for B), and its alternate-mode bit is clear (bit 2 for A, bit 3 for B). Otherwise its output is low and its counters are cleared, so a re-enabled channel starts with a full high phase.
- R6: A high count of 0 gives a constant low output while the channel runs.
- R7: A low count of 0 with a nonzero high count gives a constant high output.
- R8: A phase-count write made while a channel runs takes effect only at the end of the period in progress. That period finishes with its old high and low lengths.
- R9: A single control write changes the fields of both channels on the same edge. The output of a newly enabled channel rises in the cycle right after that edge.
- R10: Synchronous active-high `rst` clears every register word, so both outputs are low and every word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| src_tick | input | 4 | Time-base enable strobes, one per select code |
| pwm_out | output | 2 | Pulse outputs, bit 0 channel A, bit 1 channel B |

## Verification
A write becomes visible one clock after the edge that captures it. The bench therefore checks read-back and the enable response (R9) at the falling edge that follows the capture edge. Read data is combinational and is sampled one time unit after the address changes. Waveform lengths are measured in ticks of the selected source rather than in clock cycles: each output level is sampled at a falling edge, and the tick that the bench drives for the next rising edge is credited to that level. A run then closes at exactly hi×(div+1) or lo×(div+1) ticks, whatever the strobe density. The partial run that spans a reconfiguration is discarded before any comparison.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 7;
    localparam int SEL_W  = 2;
    localparam int N_SRC  = 1 << SEL_W;
    localparam int N_CH   = 2;
    localparam int IDX_CTRL = 2;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } phase_cnt_t;

    typedef struct packed {
        logic             pre_en;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             alt_mode;
        logic             run_en;
    } chan_cfg_t;

    typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

    // Pull one channel's fields out of the shared control word.
    function automatic chan_cfg_t ctrl_field(input logic [DATA_W-1:0] w, input int ch);
        chan_cfg_t c;
        c.pre_en   = w[15 + 8*ch];
        c.div      = w[8 + 8*ch +: DIV_W];
        c.sel      = w[4 + 2*ch +: SEL_W];
        c.alt_mode = w[2 + ch];
        c.run_en   = w[ch];
        return c;
    endfunction
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int AW = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [AW-1:0]                addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [N_CH-1:0][DATA_W-1:0]  duty_o,
    output logic [DATA_W-1:0]            ctrl_o
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    for (genvar g = 0; g < N_CH; g++) begin : g_duty
        assign duty_o[g] = mem[g];
    end
    assign ctrl_o = mem[IDX_CTRL];

    AST_DUTY_A_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == AW'(0) |=> duty_o[0] == $past(wdata)); // R1
    AST_CTRL_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == AW'(IDX_CTRL) |=> ctrl_o == $past(wdata)); // R9
endmodule

// File: rtl/pwm2_presc.sv
module pwm2_presc
    import pwm2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    logic [DIV_W-1:0] pc;
    logic             wrap;

    // >= keeps the count bounded if div is lowered mid-count
    assign wrap = (pc >= div);
    assign step = !hold && tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pc <= '0;
        end else if (tick) begin
            pc <= wrap ? '0 : pc + 1'b1;
        end
    end

    AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hold |=> pc == '0); // R5
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
    import pwm2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_cfg_t        cfg,
    input  phase_cnt_t       duty,
    input  logic [N_SRC-1:0] src_tick,
    output logic             pwm_o
);
    logic       active;
    logic       tick;
    logic       step;
    phase_cnt_t cur;
    phase_e     ph;
    logic [CNT_W-1:0] cnt;
    logic       hi_end;
    logic       lo_end;
    logic       boundary;

    assign active = cfg.run_en && cfg.pre_en && !cfg.alt_mode;
    assign tick   = src_tick[cfg.sel];

    pwm2_presc u_presc (
        .clk  (clk),
        .rst  (rst),
        .hold (!active),
        .tick (tick),
        .div  (cfg.div),
        .step (step)
    );

    assign hi_end   = step && ph == PH_HIGH && (cnt + 1'b1) == cur.hi;
    assign lo_end   = step && ph == PH_LOW && (cur.lo == '0 || (cnt + 1'b1) == cur.lo);
    assign boundary = lo_end || (hi_end && cur.lo == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            ph  <= PH_LOW;
            cnt <= '0;
        end else if (!active || boundary) begin
            cur <= duty;
            ph  <= (duty.hi != '0) ? PH_HIGH : PH_LOW;
            cnt <= '0;
        end else if (hi_end) begin
            ph  <= PH_LOW;
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pwm_o = active && ph == PH_HIGH;

    AST_HI_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        cur.hi == '0 |-> !pwm_o); // R6
    AST_LO_ZERO_HIGH: assert property (@(posedge clk) disable iff (rst)
        active && cur.hi != '0 && cur.lo == '0 |-> pwm_o); // R7
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !active |=> cnt == '0); // R5
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        active && !boundary |=> $stable(cur)); // R8
    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
        ph == PH_HIGH |-> cnt < cur.hi); // R2
endmodule

// File: rtl/pwm2_top.sv
module pwm2_top
    import pwm2_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int AW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_tick,
    output logic [N_CH-1:0]   pwm_out
);
    logic [N_CH-1:0][DATA_W-1:0] duty_w;
    logic [DATA_W-1:0]           ctrl_w;

    pwm2_regs #(.WORDS(WORDS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .duty_o (duty_w),
        .ctrl_o (ctrl_w)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm2_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg      (ctrl_field(ctrl_w, g)),
            .duty     (phase_cnt_t'(duty_w[g])),
            .src_tick (src_tick),
            .pwm_o    (pwm_out[g])
        );
    end
endmodule

// File: tb/tb_pwm2_top.sv
module tb_pwm2_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    int tick_mode = 0;
    int sel_b [2];
    int run_len [2];
    logic prev_o [2];
    bit q_lvl [2][$];
    int q_len [2][$];
    bit done = 0;

    pwm2_top dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    // Run-length monitor, counted in ticks of each channel's selected source
    always @(negedge clk) begin
        logic [3:0] nt;
        nt = (tick_mode == 0) ? 4'hF : 4'($urandom());
        for (int ch = 0; ch < 2; ch++) begin
            if (!rst && pwm_out[ch] !== prev_o[ch]) begin
                q_lvl[ch].push_back(prev_o[ch]);
                q_len[ch].push_back(run_len[ch]);
                run_len[ch] = 0;
            end
            prev_o[ch] = pwm_out[ch];
            run_len[ch] += int'(nt[sel_b[ch]]);
        end
        src_tick = nt;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(
        input bit ra, input bit aa, input int sa, input int da, input bit pa,
        input bit rb, input bit ab, input int sb, input int db, input bit pb);
        logic [31:0] w;
        w = '0;
        w[0] = ra; w[1] = rb; w[2] = aa; w[3] = ab;
        w[5:4] = 2'(sa); w[7:6] = 2'(sb);
        w[14:8] = 7'(da); w[15] = pa;
        w[22:16] = 7'(db); w[23] = pb;
        return w;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic clear_q(input int ch);
        @(negedge clk); #1;
        q_lvl[ch].delete();
        q_len[ch].delete();
    endtask

    // Drop the first (partial) run, then compare 2*np runs.
    task automatic expect_runs(input int ch, input int hi_t, input int lo_t,
                               input int np, input string req);
        while (q_len[ch].size() < 2*np + 1) @(negedge clk);
        for (int i = 1; i <= 2*np; i++) begin
            chk(req, q_len[ch][i], q_lvl[ch][i] ? hi_t : lo_t);
        end
    endtask

    task automatic watch_level(input int ch, input bit lvl, input int cyc, input string req);
        int miss;
        miss = 0;
        repeat (cyc) begin
            @(negedge clk); #1;
            if (pwm_out[ch] !== lvl) miss++;
        end
        chk(req, miss, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        sel_b[0] = 0; sel_b[1] = 0;
        run_len[0] = 0; run_len[1] = 0;
        prev_o[0] = 1'b0; prev_o[1] = 1'b0;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        #1;
        chk("R10 out", pwm_out, 0);
        for (int a = 0; a < 8; a++) rd_chk(a, 32'h0, "R10 word");

        // R1: storage and read-back of every word
        wr(5, 32'hFFFF_FFFF);
        rd_chk(5, 32'hFFFF_FFFF, "R1 spare word");
        wr(3, 32'h1234_ABCD);
        rd_chk(3, 32'h1234_ABCD, "R1 spare word");
        wr(1, 32'h0007_0009);
        rd_chk(1, 32'h0007_0009, "R1 duty B");
        wr(2, 32'hA500_0000);
        rd_chk(2, 32'hA500_0000, "R1 ctrl unused bits");
        chk("R1 unused bits no run", pwm_out, 0);
        wr(2, 32'h0);

        // R2/R9: both channels start together on one control write
        tick_mode = 0;
        wr(0, {16'd5, 16'd3});
        wr(1, {16'd4, 16'd6});
        clear_q(0); clear_q(1);
        wr(2, mk_ctrl(1,0,0,0,1, 1,0,0,0,1));
        chk("R9 both rise", pwm_out, 3);
        expect_runs(0, 5, 3, 2, "R2 chA 5/3");
        expect_runs(1, 4, 6, 2, "R2 chB 4/6");

        // R8: mid-period update waits for the period end
        wr(1, {16'd0, 16'd0});
        @(negedge clk);
        while (pwm_out[0] !== 1'b0) @(negedge clk);
        while (pwm_out[0] !== 1'b1) @(negedge clk);
        #1;
        q_lvl[0].delete(); q_len[0].delete();
        @(negedge clk);
        wr(0, {16'd2, 16'd7});
        while (q_len[0].size() < 4) @(negedge clk);
        chk("R8 old high kept", q_len[0][0], 5);
        chk("R8 old low kept", q_len[0][1], 3);
        chk("R8 new high", q_len[0][2], 2);
        chk("R8 new low", q_len[0][3], 7);

        // R5: disable mid-high, re-enable gives a full high phase
        wr(0, {16'd6, 16'd4});
        while (pwm_out[0] !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(2, 32'h0);
        chk("R5 off low", pwm_out[0], 0);
        clear_q(0);
        wr(2, mk_ctrl(1,0,0,0,1, 0,0,0,0,0));
        while (q_len[0].size() < 2) @(negedge clk);
        chk("R5 first high full", q_len[0][1], 6);

        // R5: alternate-mode bit and prescaler enable each force low
        wr(2, mk_ctrl(1,1,0,0,1, 0,0,0,0,0));
        watch_level(0, 1'b0, 30, "R5 alt mode low");
        wr(2, mk_ctrl(1,0,0,0,0, 0,0,0,0,0));
        watch_level(0, 1'b0, 30, "R5 prescaler off low");

        // R6 / R7: constant levels
        wr(2, 32'h0);
        wr(0, {16'd0, 16'd5});
        wr(2, mk_ctrl(1,0,0,0,1, 0,0,0,0,0));
        watch_level(0, 1'b0, 40, "R6 hi=0 low");
        wr(2, 32'h0);
        wr(1, {16'd4, 16'd0});
        wr(2, mk_ctrl(0,0,0,0,0, 1,0,0,0,1));
        watch_level(1, 1'b1, 40, "R7 lo=0 high");

        // R3: largest divider
        wr(2, 32'h0);
        wr(0, {16'd1, 16'd1});
        clear_q(0);
        wr(2, mk_ctrl(1,0,0,127,1, 0,0,0,0,0));
        expect_runs(0, 128, 128, 1, "R3 div 127");

        // R2/R3/R4: random counts, dividers, sources and strobe density
        for (int it = 0; it < 8; it++) begin
            int ha, la, da, sa, hb, lb, db, sb;
            ha = 1 + int'($urandom_range(19)); la = 1 + int'($urandom_range(19));
            hb = 1 + int'($urandom_range(19)); lb = 1 + int'($urandom_range(19));
            da = int'($urandom_range(3)); db = int'($urandom_range(3));
            sa = int'($urandom_range(3)); sb = int'($urandom_range(3));
            wr(2, 32'h0);
            tick_mode = it % 2;
            sel_b[0] = sa; sel_b[1] = sb;
            wr(0, {16'(ha), 16'(la)});
            wr(1, {16'(hb), 16'(lb)});
            clear_q(0); clear_q(1);
            wr(2, mk_ctrl(1,0,sa,da,1, 1,0,sb,db,1));
            expect_runs(0, ha*(da+1), la*(da+1), 2, "R4 R3 random chA");
            expect_runs(1, hb*(db+1), lb*(db+1), 2, "R4 R3 random chB");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule